// File: doc/BRIEF.md
# SPI Memory Transaction Master

This block is an SPI host that reads and writes the memory of a peripheral with a 22-bit byte address space. A client hands it one command at a time. Each command carries a direction, a start address, a count of data bytes and, for writes, a count of trailing zero bytes. The block then runs the whole transaction under a single chip-select assertion. It sends an address header, adds a dummy byte on reads, and then moves the data bytes.

Write data is pulled from the client through a valid/ready handshake. If the client falls behind, the serial clock pauses with chip select still held low. Read data is returned one byte per strobe, in the order the bytes come off the wire. Multi-byte words travel least-significant byte first in both directions, so the first data byte of a transfer is the low byte of a word. The serial clock comes from the system clock through a fixed divider: each SCLK level lasts `CLK_HALF` system clocks.

Top module: `spi_memxact_master`

## Requirements
- R1: While no transaction is in progress, and directly after reset, cs_n is 1, sclk is 0, mosi is 1 and busy is 0.
- R2: Every byte is shifted out most-significant bit first with exactly eight sclk pulses. mosi changes only while sclk is low. miso is captured on each rising sclk edge, and the first captured bit becomes bit 7 of the received byte.
- R3: A read sends a four-byte header: {2'b00, addr[21:16]}, then addr[15:8], then addr[7:0], then one 0x00 dummy byte.
- R4: A write sends a three-byte header, {2'b10, addr[21:16]}, then addr[15:8], then addr[7:0], with no dummy byte.
- R5: In the data phase of a read, mosi carries 0x00 for each of cmd_len bytes. Each received byte is presented on rd_data with rd_valid high for one clock, in wire order, so a 32-bit word is assembled least-significant byte first.
- R6: In the data phase of a write, bytes are taken on clock edges where wr_valid and wr_ready are both high and are sent in acceptance order. While wr_valid stays low, sclk stays low and cs_n stays low.
- R7: A write is followed by cmd_pad bytes of 0x00 before cs_n rises. On a read, cmd_pad has no effect.
- R8: cs_n stays low without a break from the first header bit to the last data or padding bit. It rises once per transaction, after a total of header, data and padding bytes.
- R9: A command is accepted on a clock edge where cmd_valid is 1 and busy is 0. From then on, busy is 1 until cs_n rises. cmd_valid is ignored while busy is 1.
- R10: Inside a byte, sclk is high for CLK_HALF clocks, and successive rising edges are 2*CLK_HALF clocks apart.
- R11: A command with cmd_len of 0 sends only the header (and padding on a write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write transaction, 0 = read transaction |
| cmd_addr | input | 22 | Peripheral start address |
| cmd_len | input | LEN_W | Number of data bytes |
| cmd_pad | input | PAD_W | Number of zero bytes appended after write data |
| busy | output | 1 | Transaction in progress |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data byte available |
| wr_ready | output | 1 | Block takes the write byte this clock |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | One-clock strobe for rd_data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to peripheral |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from peripheral |

## Verification
The bench drives several patterns against a peripheral model that returns a distinct byte at each frame position:
- A write and a read of one 32-bit word at mid-range addresses. These separate the two header formats and check the byte order of the data.
- Both directions at the top address, 0x3FFFFF. This shows whether bit 7 of the first header byte is set on writes and whether the top two bits are cleared on reads.
- A write with padding and a deliberate gap in write data. This checks that the clock pauses and the frame still holds together.
- A read that is given a padding count and a stray command while busy. This confirms that both are ignored.
- Zero-length transfers in each direction. These check that the frame is cut down to the header alone.

// File: rtl/spi_mx_pkg.sv
package spi_mx_pkg;

  localparam int ADDR_W = 22;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT
  } mx_state_e;

  typedef enum logic [1:0] {
    SEG_HDR,
    SEG_DATA,
    SEG_PAD
  } mx_seg_e;

  // index of the last header byte: writes have three, reads four (dummy)
  function automatic logic [1:0] hdr_last(input logic is_wr);
    return is_wr ? 2'd2 : 2'd3;
  endfunction

  // header byte at position idx; top byte flags direction in bits 7:6
  function automatic logic [7:0] hdr_byte(input logic is_wr,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic [1:0] idx);
    logic [7:0] b;
    case (idx)
      2'd0:    b = {is_wr, 1'b0, addr[21:16]};
      2'd1:    b = addr[15:8];
      2'd2:    b = addr[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/spi_mx_shifter.sv
module spi_mx_shifter #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       done,
  output logic [7:0] rx_byte
);

  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [CW-1:0] DIV_END = CW'(CLK_HALF - 1);

  logic [CW-1:0] div_q;
  logic          hi_q;
  logic [2:0]    bits_left_q;
  logic [7:0]    tx_sh_q;
  logic [7:0]    rx_sh_q;
  logic          div_wrap;

  assign div_wrap = (div_q == DIV_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q       <= '0;
      hi_q        <= 1'b0;
      bits_left_q <= 3'd0;
      tx_sh_q     <= 8'h00;
      rx_sh_q     <= 8'h00;
      active      <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active      <= 1'b1;
        tx_sh_q     <= tx_byte;
        bits_left_q <= 3'd7;
        div_q       <= '0;
        hi_q        <= 1'b0;
      end else if (active) begin
        if (div_wrap) begin
          div_q <= '0;
          if (!hi_q) begin
            hi_q    <= 1'b1;
            rx_sh_q <= {rx_sh_q[6:0], miso};
          end else begin
            hi_q <= 1'b0;
            if (bits_left_q == 3'd0) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bits_left_q <= bits_left_q - 3'd1;
              tx_sh_q     <= {tx_sh_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk    = hi_q;
  assign mosi    = active ? tx_sh_q[7] : 1'b1;
  assign rx_byte = rx_sh_q;

endmodule

// File: rtl/spi_mx_seq.sv
module spi_mx_seq
  import spi_mx_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int PAD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [PAD_W-1:0]  cmd_pad,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx,
  output logic              eng_start,
  output logic [7:0]        eng_tx,
  output logic              cs_n,
  output logic              busy,
  output logic              accept,
  output logic              op_wr
);

  mx_state_e         st_q;
  mx_seg_e           seg_q;
  logic [1:0]        idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_left_q;
  logic [PAD_W-1:0]  pad_left_q;

  logic has_data, has_pad, data_last, pad_last, hdr_end;

  assign accept    = (st_q == ST_IDLE) && cmd_valid;
  assign has_data  = (len_left_q != '0);
  assign has_pad   = (pad_left_q != '0);
  assign data_last = (len_left_q == LEN_W'(1));
  assign pad_last  = (pad_left_q == PAD_W'(1));
  assign hdr_end   = (idx_q == hdr_last(op_wr));

  always_comb begin
    eng_start = 1'b0;
    eng_tx    = 8'h00;
    wr_ready  = 1'b0;
    if (st_q == ST_LOAD) begin
      case (seg_q)
        SEG_HDR: begin
          eng_start = 1'b1;
          eng_tx    = hdr_byte(op_wr, addr_q, idx_q);
        end
        SEG_DATA: begin
          if (op_wr) begin
            wr_ready  = 1'b1;
            eng_start = wr_valid;
            eng_tx    = wr_data;
          end else begin
            eng_start = 1'b1;
          end
        end
        default: eng_start = 1'b1;
      endcase
    end
  end

  assign rd_valid = (st_q == ST_SHIFT) && eng_done && (seg_q == SEG_DATA) && !op_wr;
  assign rd_data  = eng_rx;
  assign cs_n     = (st_q == ST_IDLE);
  assign busy     = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      seg_q      <= SEG_HDR;
      idx_q      <= 2'd0;
      addr_q     <= '0;
      len_left_q <= '0;
      pad_left_q <= '0;
      op_wr      <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            op_wr      <= cmd_write;
            addr_q     <= cmd_addr;
            len_left_q <= cmd_len;
            pad_left_q <= cmd_write ? cmd_pad : '0;
            seg_q      <= SEG_HDR;
            idx_q      <= 2'd0;
            st_q       <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (eng_start) st_q <= ST_SHIFT;
        end
        default: begin
          if (eng_done) begin
            st_q <= ST_LOAD;
            case (seg_q)
              SEG_HDR: begin
                if (!hdr_end) begin
                  idx_q <= idx_q + 2'd1;
                end else if (has_data) begin
                  seg_q <= SEG_DATA;
                end else if (has_pad) begin
                  seg_q <= SEG_PAD;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              SEG_DATA: begin
                len_left_q <= len_left_q - 1'b1;
                if (data_last) begin
                  if (has_pad) seg_q <= SEG_PAD;
                  else         st_q  <= ST_IDLE;
                end
              end
              default: begin
                pad_left_q <= pad_left_q - 1'b1;
                if (pad_last) st_q <= ST_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/spi_memxact_master.sv
module spi_memxact_master
  import spi_mx_pkg::*;
#(
  parameter int CLK_HALF = 2,
  parameter int LEN_W    = 12,
  parameter int PAD_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [PAD_W-1:0]  cmd_pad,
  output logic              busy,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);

  logic       eng_start, eng_done, eng_active;
  logic [7:0] eng_tx, eng_rx;
  logic       accept, op_wr;

  spi_mx_seq #(.LEN_W(LEN_W), .PAD_W(PAD_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_pad(cmd_pad),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .eng_done(eng_done), .eng_rx(eng_rx), .eng_start(eng_start), .eng_tx(eng_tx),
    .cs_n(cs_n), .busy(busy), .accept(accept), .op_wr(op_wr)
  );

  spi_mx_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .tx_byte(eng_tx), .miso(miso),
    .sclk(sclk), .mosi(mosi), .active(eng_active),
    .done(eng_done), .rx_byte(eng_rx)
  );

endmodule

// File: rtl/spi_memxact_master_chk.sv
module spi_memxact_master_chk #(
  parameter int CLK_HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic accept,
  input logic wr_ready,
  input logic rd_valid,
  input logic op_wr,
  input logic eng_active
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 16'd0;
    else        hi_cnt <= sclk ? hi_cnt + 16'd1 : 16'd0;
  end

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && mosi));

  a_r8_clock_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk || eng_active) |-> !cs_n);

  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r9_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r5_read_strobe_dir: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && !op_wr));

  a_r6_ready_only_writes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && op_wr && !sclk && !eng_active));

  a_r10_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == 16'(CLK_HALF)));

endmodule

bind spi_memxact_master spi_memxact_master_chk #(.CLK_HALF(CLK_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .sclk(sclk),
  .mosi(mosi), .accept(accept), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .op_wr(op_wr), .eng_active(eng_active)
);

// File: tb/spi_memxact_master_tb.sv
module spi_memxact_master_tb;

  localparam int CLK_HALF = 2;
  localparam int LEN_W    = 12;
  localparam int PAD_W    = 3;
  localparam int TCLK     = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [21:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [PAD_W-1:0] cmd_pad = '0;
  logic [7:0] wr_data = 8'h00;
  logic wr_valid = 1'b0;
  logic busy, wr_ready, rd_valid, sclk, mosi, cs_n, miso;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  spi_memxact_master #(.CLK_HALF(CLK_HALF), .LEN_W(LEN_W), .PAD_W(PAD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_pad(cmd_pad), .busy(busy),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .miso(miso)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_mosi[$];
  string      exp_tag[$];
  logic [7:0] exp_rd[$];
  int         exp_len[$];
  logic [7:0] rd_log[$];
  logic [7:0] wbuf[0:15];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] slave_byte(input int i);
    return 8'((60 + i * 71) & 255);
  endfunction

  // peripheral model: new bit after each falling sclk
  int s_byte = 0;
  logic [2:0] s_bit = 3'd0;
  logic [7:0] cur_resp;
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin s_byte = 0; s_bit = 3'd0; end
    else if (s_bit == 3'd7) begin s_bit = 3'd0; s_byte++; end
    else s_bit = s_bit + 3'd1;
  end
  always_comb cur_resp = slave_byte(s_byte);
  assign miso = cs_n ? 1'b1 : cur_resp[~s_bit];

  // mosi monitor (R2, R10)
  logic [7:0] m_sh = 8'h00;
  int m_bits = 0, m_bytes = 0;
  time last_rise = 0;
  always @(posedge sclk) begin
    if (m_bits > 0)
      chk(($time - last_rise) == 2 * CLK_HALF * TCLK, "R10", 32'($time - last_rise), 32'(2 * CLK_HALF * TCLK));
    last_rise = $time;
    m_sh = {m_sh[6:0], mosi};
    m_bits++;
    if (m_bits == 8) begin
      m_bits = 0;
      m_bytes++;
      if (exp_mosi.size() == 0) chk(1'b0, "R8 extra byte", 32'(m_sh), 32'hFFFF_FFFF);
      else begin
        logic [7:0] e;
        string t;
        e = exp_mosi.pop_front();
        t = exp_tag.pop_front();
        chk(m_sh == e, {t, " R2 mosi byte"}, 32'(m_sh), 32'(e));
      end
    end
  end

  // frame monitor (R8)
  always @(posedge cs_n) begin
    if (exp_len.size() != 0 || m_bytes != 0) begin
      int e;
      e = (exp_len.size() != 0) ? exp_len.pop_front() : -1;
      chk(m_bytes == e && m_bits == 0, "R8 frame length", 32'(m_bytes), 32'(e));
    end
    m_bytes = 0;
    m_bits = 0;
  end

  // read monitor (R5)
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_log.push_back(rd_data);
      if (exp_rd.size() == 0) chk(1'b0, "R5 extra rd_valid", 32'(rd_data), 32'hFFFF_FFFF);
      else begin
        logic [7:0] e;
        e = exp_rd.pop_front();
        chk(rd_data == e, "R5 rd_data", 32'(rd_data), 32'(e));
      end
    end
  end

  task automatic xact(input bit wr, input logic [21:0] a, input int len, input int pad,
                      input int stall_at, input bit poke);
    exp_mosi.push_back(wr ? (8'h80 | {2'b00, a[21:16]}) : {2'b00, a[21:16]});
    exp_tag.push_back(wr ? "R4" : "R3");
    exp_mosi.push_back(a[15:8]);  exp_tag.push_back(wr ? "R4" : "R3");
    exp_mosi.push_back(a[7:0]);   exp_tag.push_back(wr ? "R4" : "R3");
    if (!wr) begin exp_mosi.push_back(8'h00); exp_tag.push_back("R3"); end
    for (int k = 0; k < len; k++) begin
      if (wr) begin exp_mosi.push_back(wbuf[k]); exp_tag.push_back("R6"); end
      else begin
        exp_mosi.push_back(8'h00); exp_tag.push_back("R5");
        exp_rd.push_back(slave_byte(4 + k));
      end
    end
    if (wr) for (int k = 0; k < pad; k++) begin exp_mosi.push_back(8'h00); exp_tag.push_back("R7"); end
    exp_len.push_back((wr ? 3 : 4) + len + (wr ? pad : 0));

    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_write = wr; cmd_addr = a; cmd_len = LEN_W'(len); cmd_pad = PAD_W'(pad);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cs_n, "R9 accept", {30'd0, busy, cs_n}, 32'h2);

    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_write = 1'b1; cmd_addr = 22'h155555; cmd_len = LEN_W'(2);
      cmd_valid = 1'b1;
      repeat (5) @(negedge clk);
      cmd_valid = 1'b0;
    end

    if (wr) begin
      for (int k = 0; k < len; k++) begin
        if (k == stall_at) begin
          while (!wr_ready) @(negedge clk);
          for (int s = 0; s < 20; s++) begin
            @(negedge clk);
            if (s % 5 == 4)
              chk(!sclk && !cs_n && wr_ready, "R6 stall", {29'd0, sclk, cs_n, wr_ready}, 32'h1);
          end
        end
        wr_valid = 1'b1; wr_data = wbuf[k];
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
      end
    end

    while (busy) @(negedge clk);
    chk(cs_n && !sclk && mosi, "R1 idle after", {29'd0, cs_n, sclk, mosi}, 32'h5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=idle");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] word, wexp;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && mosi && !busy && !rd_valid && !wr_ready, "R1 reset",
        {26'd0, cs_n, sclk, mosi, busy, rd_valid, wr_ready}, 32'h28);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && !sclk && mosi && !busy, "R1 after reset", {28'd0, cs_n, sclk, mosi, busy}, 32'ha);

    // one 32-bit word out, least significant byte first (R4, R6)
    wbuf[0] = 8'h78; wbuf[1] = 8'h56; wbuf[2] = 8'h34; wbuf[3] = 8'h12;
    xact(1'b1, 22'h2BCDEF, 4, 0, -1, 1'b0);

    // one 32-bit word in (R3, R5)
    rd_log.delete();
    xact(1'b0, 22'h2A1357, 4, 0, -1, 1'b0);
    word = '0;
    if (rd_log.size() == 4) word = {rd_log[3], rd_log[2], rd_log[1], rd_log[0]};
    wexp = {slave_byte(7), slave_byte(6), slave_byte(5), slave_byte(4)};
    chk(word == wexp, "R5 word LSB first", word, wexp);

    // write with padding and a data gap (R6, R7)
    wbuf[0] = 8'hC3; wbuf[1] = 8'h01; wbuf[2] = 8'hFE;
    xact(1'b1, 22'h001234, 3, 5, 1, 1'b0);

    // read with ignored padding and a stray command while busy (R7, R9)
    xact(1'b0, 22'h3F0080, 2, 3, -1, 1'b1);
    repeat (5) @(negedge clk);
    chk(!busy && cs_n, "R9 stray cmd ignored", {30'd0, busy, cs_n}, 32'h1);

    // header-only transfers (R11)
    xact(1'b1, 22'h0000A5, 0, 0, -1, 1'b0);
    xact(1'b0, 22'h0000A5, 0, 0, -1, 1'b0);

    // top of the address range (R3, R4)
    wbuf[0] = 8'h5A;
    xact(1'b1, 22'h3FFFFF, 1, 1, -1, 1'b0);
    xact(1'b0, 22'h3FFFFF, 1, 0, -1, 1'b0);

    repeat (10) @(negedge clk);
    chk(exp_mosi.size() == 0 && exp_len.size() == 0 && exp_rd.size() == 0, "R8 all frames seen",
        32'(exp_mosi.size() + exp_len.size() + exp_rd.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule